// File: doc/BRIEF.md
# Attention Interrupt Controller

This block turns the attention state of a host-to-controller message interface into one level-sensitive interrupt line toward the host. It holds a small mask register with two live bits: an enable bit and a pending-status bit. The interrupt line is the pending bit. Several things can set pending: an enable write while attention is already pending, a response-ready event from the controller side, or the controller raising its unsolicited-message ("SMS") attention flag. Host writes and controller actions can clear it again.

The control register that holds the response attention flag is decoded elsewhere. That flag enters as a plain level input. The SMS attention flag is kept inside this block, because a request that leaves it unchanged must have no effect. A strap says whether an interrupt line is wired at all. A global enable from the platform gates the event-driven paths. A reset-event input carries a kind bit: a cold reset clears the mask bits, and a warm reset leaves them alone.

Every update is registered. A write or event sampled at one clock edge shows on the outputs just after that edge.

Top module: `atn_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, `mask_rdata_o`, `irq_o` and `sms_atn_o` are all 0. Mask read bit 0 is enable, bit 1 is pending, and all other bits read 0. `irq_o` always equals bit 1, and pending is never 1 while enable is 0.
- R2: A mask write with bit 0 = 1 while enable is 0 sets enable. If `resp_atn_i` or the SMS flag is 1 at that moment, the same write also sets pending. Otherwise pending stays 0.
- R3: A mask write with bit 0 = 0 while enable is 1 clears both enable and pending, so `irq_o` drops.
- R4: A mask write with bit 1 = 1 while pending is 1 clears pending. A write with bit 1 = 0 leaves pending as it was. Within one write, the enable change is applied first and the bit-1 clear second. So writing 0x03 from the disabled state with attention present leaves the register at 0x01.
- R5: A response-ready pulse sets pending only when `irq_present_i`, `glb_irq_en_i` and enable are all 1.
- R6: An SMS request that changes the flag from 0 to 1 updates `sms_atn_o`. It sets pending only when `sms_irq_i`, `irq_present_i`, `glb_irq_en_i` and enable are 1 and `resp_atn_i` is 0.
- R7: An SMS request whose value equals the current flag changes neither the flag nor the mask bits.
- R8: An SMS request that changes the flag from 1 to 0 clears pending only when `resp_atn_i` is 0.
- R9: A reset event with `rst_cold_i` = 1 clears enable and pending, overriding any write or event in the same cycle. With `rst_cold_i` = 0 it leaves the mask bits unchanged.
- R10: Outputs change only at the clock edge that samples the stimulus. Inputs present in the same cycle are applied in this order: mask write, then response-ready, then SMS request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_atn_i | input | 1 | Response attention level from the control register |
| rsp_ready_i | input | 1 | One-cycle response-ready event |
| sms_req_i | input | 1 | SMS attention request strobe |
| sms_val_i | input | 1 | Requested SMS attention value |
| sms_irq_i | input | 1 | Request may raise the interrupt |
| glb_irq_en_i | input | 1 | Platform-wide interrupt enable |
| irq_present_i | input | 1 | Strap: an interrupt line is wired |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | DATA_W | Mask write data |
| rst_evt_i | input | 1 | Reset event strobe |
| rst_cold_i | input | 1 | Reset event is cold (1) or warm (0) |
| irq_o | output | 1 | Level interrupt to the host |
| mask_rdata_o | output | DATA_W | Mask register read value |
| sms_atn_o | output | 1 | Current SMS attention flag |

## Verification
Each result is due exactly one clock edge after its stimulus. The mask bits, the interrupt line and the SMS flag all sit one register stage from the inputs. The bench drives every strobe on a falling edge, so the rising edge samples it, and it removes the strobe and checks the outputs on the next falling edge. One check also samples before the rising edge, to confirm that nothing moves early. The same-cycle ordering cases drive a write together with an event in a single cycle and compare against the sequential result.

// File: rtl/atn_irq_pkg.sv
package atn_irq_pkg;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PEND_BIT = 1;
  localparam int unsigned LIVE_W   = 2;

  typedef struct packed {
    logic pend;
    logic en;
  } mask_t;
endpackage

// File: rtl/atn_sms_flag.sv
module atn_sms_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic val_i,
  output logic flag_o,
  output logic set_o,
  output logic clr_o
);
  logic flag_q;
  logic flag_d;
  logic chg;

  always_comb begin
    chg    = req_i && (val_i != flag_q);
    flag_d = chg ? val_i : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (chg) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign set_o  = chg && val_i;
  assign clr_o  = chg && !val_i;
endmodule

// File: rtl/atn_mask_next.sv
module atn_mask_next
  import atn_irq_pkg::*;
(
  input  mask_t cur_i,
  input  logic  wr_i,
  input  logic  wr_en_bit_i,
  input  logic  wr_ack_bit_i,
  input  logic  resp_atn_i,
  input  logic  sms_atn_i,
  input  logic  rsp_evt_i,
  input  logic  sms_set_i,
  input  logic  sms_irq_i,
  input  logic  sms_clr_i,
  input  logic  glb_en_i,
  input  logic  present_i,
  input  logic  cold_i,
  output mask_t nxt_o,
  output logic  upd_o
);
  logic  line_ok;
  mask_t m;

  always_comb begin
    line_ok = present_i && glb_en_i;
    m       = cur_i;
    // step 1: host write, enable change first, then acknowledge
    if (wr_i) begin
      if (wr_en_bit_i != m.en) begin
        if (wr_en_bit_i) begin
          if (resp_atn_i || sms_atn_i) begin
            m.pend = 1'b1;
          end
          m.en = 1'b1;
        end else begin
          m.pend = 1'b0;
          m.en   = 1'b0;
        end
      end
      if (wr_ack_bit_i && m.pend) begin
        m.pend = 1'b0;
      end
    end
    // step 2: response ready
    if (rsp_evt_i && line_ok && m.en && !m.pend) begin
      m.pend = 1'b1;
    end
    // step 3: SMS attention change
    if (sms_set_i && sms_irq_i && line_ok && !resp_atn_i && m.en) begin
      m.pend = 1'b1;
    end
    if (sms_clr_i && !resp_atn_i && m.pend) begin
      m.pend = 1'b0;
    end
    // cold reset overrides everything
    if (cold_i) begin
      m = '0;
    end
    nxt_o = m;
    upd_o = (m != cur_i);
  end
endmodule

// File: rtl/atn_mask_regs.sv
module atn_mask_regs
  import atn_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  mask_t             nxt_i,
  output mask_t             cur_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  mask_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (upd_i) begin
      mask_q <= nxt_i;
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[EN_BIT]   = mask_q.en;
    rdata_o[PEND_BIT] = mask_q.pend;
  end

  assign cur_o = mask_q;
  assign irq_o = mask_q.pend;
endmodule

// File: rtl/atn_irq_ctrl.sv
module atn_irq_ctrl
  import atn_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resp_atn_i,
  input  logic              rsp_ready_i,
  input  logic              sms_req_i,
  input  logic              sms_val_i,
  input  logic              sms_irq_i,
  input  logic              glb_irq_en_i,
  input  logic              irq_present_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  input  logic              rst_evt_i,
  input  logic              rst_cold_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] mask_rdata_o,
  output logic              sms_atn_o
);
  logic  sms_flag;
  logic  sms_set;
  logic  sms_clr;
  logic  cold;
  logic  upd;
  mask_t cur;
  mask_t nxt;

  assign cold = rst_evt_i && rst_cold_i;

  generate
    if (DATA_W > LIVE_W) begin : g_spare
      logic unused_wbits;
      assign unused_wbits = ^mask_wdata_i[DATA_W-1:LIVE_W];
    end
  endgenerate

  atn_sms_flag u_sms (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (sms_req_i),
    .val_i  (sms_val_i),
    .flag_o (sms_flag),
    .set_o  (sms_set),
    .clr_o  (sms_clr)
  );

  atn_mask_next u_next (
    .cur_i        (cur),
    .wr_i         (mask_wr_i),
    .wr_en_bit_i  (mask_wdata_i[EN_BIT]),
    .wr_ack_bit_i (mask_wdata_i[PEND_BIT]),
    .resp_atn_i   (resp_atn_i),
    .sms_atn_i    (sms_flag),
    .rsp_evt_i    (rsp_ready_i),
    .sms_set_i    (sms_set),
    .sms_irq_i    (sms_irq_i),
    .sms_clr_i    (sms_clr),
    .glb_en_i     (glb_irq_en_i),
    .present_i    (irq_present_i),
    .cold_i       (cold),
    .nxt_o        (nxt),
    .upd_o        (upd)
  );

  atn_mask_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (upd),
    .nxt_i   (nxt),
    .cur_o   (cur),
    .irq_o   (irq_o),
    .rdata_o (mask_rdata_o)
  );

  assign sms_atn_o = sms_flag;
endmodule

// File: rtl/atn_irq_ctrl_chk.sv
module atn_irq_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              resp_atn_i,
  input logic              rsp_ready_i,
  input logic              sms_req_i,
  input logic              sms_val_i,
  input logic              irq_present_i,
  input logic              mask_wr_i,
  input logic [DATA_W-1:0] mask_wdata_i,
  input logic              rst_evt_i,
  input logic              rst_cold_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] mask_rdata_o,
  input logic              sms_atn_o
);
  p_pend_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rdata_o[1] |-> mask_rdata_o[0]);

  p_disable_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && !mask_wdata_i[0] && mask_rdata_o[0]) |=> (!irq_o && !mask_rdata_o[0]));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && mask_wdata_i[1:0] == 2'b11 && mask_rdata_o[1:0] == 2'b11
     && !rsp_ready_i && !sms_req_i) |=> !irq_o);

  p_no_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready_i && !irq_present_i && !mask_wr_i && !sms_req_i && !irq_o) |=> !irq_o);

  p_sms_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sms_req_i && sms_val_i && resp_atn_i && !irq_o && !mask_wr_i && !rsp_ready_i) |=> !irq_o);

  p_same_sms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sms_req_i && (sms_val_i == sms_atn_o)) |=> $stable(sms_atn_o));

  p_cold_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt_i && rst_cold_i) |=> (mask_rdata_o[1:0] == 2'b00));

  p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(mask_wr_i || rsp_ready_i || sms_req_i));
endmodule

bind atn_irq_ctrl atn_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .resp_atn_i    (resp_atn_i),
  .rsp_ready_i   (rsp_ready_i),
  .sms_req_i     (sms_req_i),
  .sms_val_i     (sms_val_i),
  .irq_present_i (irq_present_i),
  .mask_wr_i     (mask_wr_i),
  .mask_wdata_i  (mask_wdata_i),
  .rst_evt_i     (rst_evt_i),
  .rst_cold_i    (rst_cold_i),
  .irq_o         (irq_o),
  .mask_rdata_o  (mask_rdata_o),
  .sms_atn_o     (sms_atn_o)
);

// File: tb/atn_irq_ctrl_bench.sv
module atn_irq_ctrl_bench;
  localparam int unsigned DATA_W = 8;

  logic clk;
  logic rst_n;
  logic resp_atn, rsp_ready, sms_req, sms_val, sms_irq, glb_en, present;
  logic mask_wr, rst_evt, rst_cold;
  logic [DATA_W-1:0] wdata;
  logic irq;
  logic [DATA_W-1:0] rdata;
  logic sms_atn;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  atn_irq_ctrl #(.DATA_W(DATA_W)) u_atn_irq_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .resp_atn_i    (resp_atn),
    .rsp_ready_i   (rsp_ready),
    .sms_req_i     (sms_req),
    .sms_val_i     (sms_val),
    .sms_irq_i     (sms_irq),
    .glb_irq_en_i  (glb_en),
    .irq_present_i (present),
    .mask_wr_i     (mask_wr),
    .mask_wdata_i  (wdata),
    .rst_evt_i     (rst_evt),
    .rst_cold_i    (rst_cold),
    .irq_o         (irq),
    .mask_rdata_o  (rdata),
    .sms_atn_o     (sms_atn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, logic [DATA_W-1:0] exp_m, logic exp_sms);
    checks++;
    if (rdata !== exp_m || irq !== exp_m[1] || sms_atn !== exp_sms) begin
      errors++;
      $display("FAIL %s: mask=%02h irq=%0b sms=%0b expected mask=%02h irq=%0b sms=%0b",
               req, rdata, irq, sms_atn, exp_m, exp_m[1], exp_sms);
    end
  endtask

  // all drive tasks start and end on a falling edge
  task automatic wr(logic [DATA_W-1:0] d);
    mask_wr = 1'b1; wdata = d;
    @(negedge clk);
    mask_wr = 1'b0; wdata = '0;
  endtask

  task automatic rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic sms(logic v, logic i);
    sms_req = 1'b1; sms_val = v; sms_irq = i;
    @(negedge clk);
    sms_req = 1'b0; sms_val = 1'b0; sms_irq = 1'b0;
  endtask

  task automatic rst_event(logic cold);
    rst_evt = 1'b1; rst_cold = cold;
    @(negedge clk);
    rst_evt = 1'b0; rst_cold = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset state", 8'h00, 1'b0);
  endtask

  task automatic t_enable();
    resp_atn = 1'b0;
    wr(8'h01); check("R2 enable without attention", 8'h01, 1'b0);
    wr(8'h00); check("R3 disable idle", 8'h00, 1'b0);
    resp_atn = 1'b1;
    wr(8'h01); check("R2 enable with response attention", 8'h03, 1'b0);
    wr(8'h00); check("R3 disable drops line", 8'h00, 1'b0);
    resp_atn = 1'b0;
  endtask

  task automatic t_ack();
    resp_atn = 1'b1;
    wr(8'h01); check("R4 setup pending", 8'h03, 1'b0);
    wr(8'h01); check("R4 bit1=0 keeps pending", 8'h03, 1'b0);
    wr(8'h03); check("R4 bit1=1 clears pending", 8'h01, 1'b0);
    wr(8'h00); check("R3 disable", 8'h00, 1'b0);
    wr(8'h03); check("R4 enable then clear in one write", 8'h01, 1'b0);
    wr(8'h00);
    resp_atn = 1'b0;
  endtask

  task automatic t_rsp();
    rsp(); check("R5 ignored while disabled", 8'h00, 1'b0);
    wr(8'h01);
    glb_en = 1'b0;
    rsp(); check("R5 ignored without global enable", 8'h01, 1'b0);
    glb_en = 1'b1; present = 1'b0;
    rsp(); check("R5 ignored without line strap", 8'h01, 1'b0);
    present = 1'b1;
    rsp(); check("R5 sets pending", 8'h03, 1'b0);
    wr(8'h03); check("R4 acknowledge", 8'h01, 1'b0);
  endtask

  task automatic t_sms();
    // enable=1, pending=0, flag=0
    sms(1'b1, 1'b0); check("R6 set without irq request", 8'h01, 1'b1);
    sms(1'b0, 1'b0); check("R8 clear flag", 8'h01, 1'b0);
    resp_atn = 1'b1;
    sms(1'b1, 1'b1); check("R6 blocked by response attention", 8'h01, 1'b1);
    rsp(); check("R5 pending from response", 8'h03, 1'b1);
    sms(1'b0, 1'b0); check("R8 clear kept by response attention", 8'h03, 1'b0);
    resp_atn = 1'b0;
    wr(8'h03); check("R4 acknowledge", 8'h01, 1'b0);
    sms(1'b1, 1'b1); check("R6 set raises line", 8'h03, 1'b1);
    wr(8'h03); check("R4 acknowledge", 8'h01, 1'b1);
    sms(1'b1, 1'b1); check("R7 equal request no raise", 8'h01, 1'b1);
    wr(8'h03);
    sms(1'b0, 1'b0); check("R8 clear", 8'h01, 1'b0);
    sms(1'b0, 1'b1); check("R7 equal clear request", 8'h01, 1'b0);
    sms(1'b1, 1'b1); check("R6 raise again", 8'h03, 1'b1);
    sms(1'b0, 1'b0); check("R8 clear drops line", 8'h01, 1'b0);
    wr(8'h00);
    sms(1'b1, 1'b0); check("R6 flag only while disabled", 8'h00, 1'b1);
    wr(8'h01); check("R2 enable with SMS attention", 8'h03, 1'b1);
    wr(8'h00);
    sms(1'b0, 1'b0); check("R8 clear idle", 8'h00, 1'b0);
  endtask

  task automatic t_reset_kinds();
    resp_atn = 1'b1;
    wr(8'h01); check("R9 setup", 8'h03, 1'b0);
    rst_event(1'b0); check("R9 warm keeps mask", 8'h03, 1'b0);
    rst_event(1'b1); check("R9 cold clears mask", 8'h00, 1'b0);
    rst_evt = 1'b1; rst_cold = 1'b1;
    wr(8'h01);
    rst_evt = 1'b0; rst_cold = 1'b0;
    check("R9 cold overrides same-cycle write", 8'h00, 1'b0);
    resp_atn = 1'b0;
  endtask

  task automatic t_order();
    rsp_ready = 1'b1;
    #1;
    check("R10 no change before edge", 8'h00, 1'b0);
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R10 response while disabled", 8'h00, 1'b0);
    rsp_ready = 1'b1; mask_wr = 1'b1; wdata = 8'h01;
    @(negedge clk);
    rsp_ready = 1'b0; mask_wr = 1'b0; wdata = '0;
    check("R10 write applied before response event", 8'h03, 1'b0);
    mask_wr = 1'b1; wdata = 8'h03; rsp_ready = 1'b1;
    @(negedge clk);
    mask_wr = 1'b0; wdata = '0; rsp_ready = 1'b0;
    check("R10 acknowledge then response re-sets", 8'h03, 1'b0);
    wr(8'h00); check("R3 final disable", 8'h00, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    resp_atn = 1'b0; rsp_ready = 1'b0; sms_req = 1'b0; sms_val = 1'b0;
    sms_irq = 1'b0; glb_en = 1'b1; present = 1'b1; mask_wr = 1'b0;
    wdata = '0; rst_evt = 1'b0; rst_cold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_ack();
    t_rsp();
    t_sms();
    t_reset_kinds();
    t_order();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule